// File: doc/BRIEF.md
# Nested Priority Interrupt Arbiter

The arbiter sits between a set of interrupt request lines and a processor core. It decides which handler the core runs next and keeps track of the execution level. Each user source has a programmable priority. A request strobe marks its source pending. The arbiter dispatches a pending source only when its priority is strictly above the level that is running now. The interrupted level goes onto a hardware level stack. When the running handler signals completion, the arbiter first looks at what is pending. If a request outranks the level waiting on top of the stack, that request is dispatched at once. Otherwise the suspended level is restored.

Level 0 belongs to the background context, which runs from reset release onwards. The topmost level is reserved for four fatal trap causes. Software can neither program a user source to that level nor mask it. Once a trap is dispatched, its handler must acknowledge it within a bounded window. If it does not, the arbiter raises a sticky reset request. The number of levels is a build parameter of 8 or 16.

Top module: `nest_irq_arbiter`

## Requirements
- R1: After reset, cur_lvl is 0, grant, reset_req and stk_ovf are low, and every user source has priority 0. A source at priority 0 is never dispatched.
- R2: A priority write with prio_val at or above the top level (NUM_LVL-1) stores NUM_LVL-2. Any other value is stored unchanged.
- R3: A pending source whose priority is strictly greater than cur_lvl is dispatched. The dispatch happens two clock edges after its request strobe. grant pulses for one cycle, grant_vec shows the source index, cur_lvl takes the priority, and the old level is pushed onto the stack.
- R4: A pending source whose priority is equal to or below cur_lvl is not dispatched while that level runs.
- R5: Among pending sources of equal highest priority, the lowest source index is dispatched first.
- R6: On hdl_done at a level above 0, a pending request whose level exceeds the stack top is dispatched in that cycle. The completed level is discarded, and the stack is not popped.
- R7: On hdl_done at a level above 0 with no pending request above the stack top, cur_lvl returns to the stack top without a grant.
- R8: Trap strobes (cause 0 divide-by-zero, 1 address error, 2 stack error, 3 oscillator failure) dispatch at level NUM_LVL-1 with grant_vec = NUM_SRC + cause. They preempt any user level, and the lowest cause index goes first.
- R9: If trap_ack does not arrive within TRAP_WAIT cycles after a trap dispatch, reset_req rises and stays high until reset.
- R10: hdl_done while cur_lvl is 0 has no effect.
- R11: The pending flag of a source is cleared at its dispatch, so one strobe gives exactly one grant.
- R12: The level stack holds NUM_LVL entries. A push into a full stack sets the sticky stk_ovf flag. Because levels only ever rise by preemption, stk_ovf stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | NUM_SRC | Per-source request strobes |
| prio_we | input | 1 | Priority register write enable |
| prio_sel | input | $clog2(NUM_SRC) | Source whose priority is written |
| prio_val | input | $clog2(NUM_LVL) | Priority value to write |
| trap_req | input | 4 | Trap cause strobes |
| trap_ack | input | 1 | Trap handler acknowledge |
| hdl_done | input | 1 | Running handler has completed |
| grant | output | 1 | One-cycle dispatch pulse |
| grant_vec | output | $clog2(NUM_SRC+4) | Vector of the last dispatch |
| cur_lvl | output | $clog2(NUM_LVL) | Level currently executing |
| reset_req | output | 1 | Sticky reset request on an unacknowledged trap |
| stk_ovf | output | 1 | Sticky level stack overflow |

## Verification
The hardest case to reach is a completion that dispatches a waiting request ahead of the suspended level. It needs two stacked handlers plus a pending request that outranks the lower one. The stimulus runs one source, preempts it with a second, and strobes the second source again while it runs. Completion then re-dispatches it rather than popping. A later completion above the background, with a low-priority request still pending, covers the same path against level 0. A second hard case puts two trap causes pending together beneath a running user handler. The stimulus shows the second trap is taken directly from the first trap's completion, and only after that does the user level resume.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
   localparam int TRAP_N = 4;

   typedef enum logic [1:0] {
      TRAP_DIVZ  = 2'd0,
      TRAP_ADDR  = 2'd1,
      TRAP_STACK = 2'd2,
      TRAP_OSC   = 2'd3
   } trap_cause_e;
endpackage

// File: rtl/irq_prio_sel.sv
module irq_prio_sel #(
   parameter int NUM_SRC = 16,
   parameter int NUM_LVL = 8,
   parameter int TRAP_N  = 4,
   parameter int LVL_W   = $clog2(NUM_LVL),
   parameter int VEC_W   = $clog2(NUM_SRC + TRAP_N)
) (
   input  logic [NUM_SRC-1:0]            pend,
   input  logic [TRAP_N-1:0]             trap_pend,
   input  logic [NUM_SRC-1:0][LVL_W-1:0] prio,
   output logic                          sel_valid,
   output logic [LVL_W-1:0]              sel_lvl,
   output logic [VEC_W-1:0]              sel_vec
);
   localparam logic [LVL_W-1:0] TOP = LVL_W'(NUM_LVL - 1);

   logic [LVL_W-1:0] best_lvl;
   logic [VEC_W-1:0] best_vec;
   logic             trap_hit;
   logic [VEC_W-1:0] trap_vec;

   // strict compare keeps the lowest index on equal levels
   always_comb begin
      best_lvl = '0;
      best_vec = '0;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (pend[i] && (prio[i] > best_lvl)) begin
            best_lvl = prio[i];
            best_vec = VEC_W'(i);
         end
      end
   end

   always_comb begin
      trap_hit = 1'b0;
      trap_vec = '0;
      for (int t = TRAP_N - 1; t >= 0; t--) begin
         if (trap_pend[t]) begin
            trap_hit = 1'b1;
            trap_vec = VEC_W'(NUM_SRC + t);
         end
      end
   end

   always_comb begin
      if (trap_hit) begin
         sel_valid = 1'b1;
         sel_lvl   = TOP;
         sel_vec   = trap_vec;
      end else begin
         sel_valid = (best_lvl != '0);
         sel_lvl   = best_lvl;
         sel_vec   = best_vec;
      end
   end

   // R8
   always_comb begin
      trap_first_chk : assert (!(|trap_pend) || (sel_lvl == TOP && sel_vec >= VEC_W'(NUM_SRC)));
   end
endmodule

// File: rtl/irq_lvl_stack.sv
module irq_lvl_stack #(
   parameter int DEPTH = 8,
   parameter int LVL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic             pop,
   input  logic [LVL_W-1:0] push_lvl,
   output logic [LVL_W-1:0] top_lvl,
   output logic             ovf
);
   localparam int SP_W  = $clog2(DEPTH + 1);
   localparam int IDX_W = $clog2(DEPTH);

   logic [LVL_W-1:0] mem [DEPTH];
   logic [SP_W-1:0]  sp_q;
   logic [SP_W-1:0]  sp_m1;

   assign sp_m1   = sp_q - SP_W'(1);
   assign top_lvl = (sp_q == '0) ? '0 : mem[sp_m1[IDX_W-1:0]];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sp_q <= '0;
         ovf  <= 1'b0;
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (push) begin
         if (sp_q == SP_W'(DEPTH)) begin
            ovf <= 1'b1;
         end else begin
            mem[sp_q[IDX_W-1:0]] <= push_lvl;
            sp_q <= sp_q + SP_W'(1);
         end
      end else if (pop && sp_q != '0) begin
         sp_q <= sp_m1;
      end
   end

   // R12
   stack_room_chk : assert property (@(posedge clk) disable iff (!rst_n)
      sp_q <= SP_W'(DEPTH - 1));

   // R10
   pop_nonempty_chk : assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> sp_q != '0);
endmodule

// File: rtl/irq_trap_watch.sv
module irq_trap_watch #(
   parameter int TRAP_WAIT = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic ack,
   output logic rst_req
);
   localparam int CNT_W = $clog2(TRAP_WAIT + 1);

   logic             armed_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         cnt_q   <= '0;
         rst_req <= 1'b0;
      end else if (arm) begin
         armed_q <= 1'b1;
         cnt_q   <= '0;
      end else if (ack) begin
         armed_q <= 1'b0;
      end else if (armed_q) begin
         if (cnt_q == CNT_W'(TRAP_WAIT - 1)) begin
            rst_req <= 1'b1;
            armed_q <= 1'b0;
         end else begin
            cnt_q <= cnt_q + CNT_W'(1);
         end
      end
   end

   // R9
   rst_hold_chk : assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> rst_req);

   // R9
   rst_cause_chk : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_req) |-> $past(armed_q));
endmodule

// File: rtl/nest_irq_arbiter.sv
module nest_irq_arbiter
   import irq_arb_pkg::*;
#(
   parameter int NUM_SRC   = 16,
   parameter int NUM_LVL   = 8,
   parameter int TRAP_WAIT = 16,
   localparam int LVL_W    = $clog2(NUM_LVL),
   localparam int SRC_W    = $clog2(NUM_SRC),
   localparam int VEC_W    = $clog2(NUM_SRC + TRAP_N)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] irq_req,
   input  logic               prio_we,
   input  logic [SRC_W-1:0]   prio_sel,
   input  logic [LVL_W-1:0]   prio_val,
   input  logic [TRAP_N-1:0]  trap_req,
   input  logic               trap_ack,
   input  logic               hdl_done,
   output logic               grant,
   output logic [VEC_W-1:0]   grant_vec,
   output logic [LVL_W-1:0]   cur_lvl,
   output logic               reset_req,
   output logic               stk_ovf
);
   localparam logic [LVL_W-1:0] TOP = LVL_W'(NUM_LVL - 1);

   if (!(NUM_LVL == 8 || NUM_LVL == 16)) begin : g_bad_lvl
      $error("NUM_LVL must be 8 or 16");
   end
   if (NUM_SRC < 2 || NUM_SRC > 16) begin : g_bad_src
      $error("NUM_SRC must lie in 2..16");
   end
   if (TRAP_WAIT < 2) begin : g_bad_wait
      $error("TRAP_WAIT must be at least 2");
   end

   logic [NUM_SRC-1:0][LVL_W-1:0] prio_q;
   logic [NUM_SRC-1:0]            pend_q;
   logic [TRAP_N-1:0]             trap_pend_q;
   logic                          sel_valid;
   logic [LVL_W-1:0]              sel_lvl;
   logic [VEC_W-1:0]              sel_vec;
   logic [LVL_W-1:0]              top_lvl;
   logic                          hdl_end, take_on_end, preempt, dispatch, pop;
   logic                          trap_arm;
   logic [LVL_W-1:0]              wr_lvl;

   // user sources never reach the trap level
   assign wr_lvl = (prio_val >= TOP) ? TOP - LVL_W'(1) : prio_val;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prio_q <= '0;
      end else if (prio_we) begin
         prio_q[prio_sel] <= wr_lvl;
      end
   end

   irq_prio_sel #(
      .NUM_SRC(NUM_SRC), .NUM_LVL(NUM_LVL), .TRAP_N(TRAP_N),
      .LVL_W(LVL_W), .VEC_W(VEC_W)
   ) u_sel (
      .pend(pend_q), .trap_pend(trap_pend_q), .prio(prio_q),
      .sel_valid(sel_valid), .sel_lvl(sel_lvl), .sel_vec(sel_vec)
   );

   assign hdl_end     = hdl_done && (cur_lvl != '0);
   assign take_on_end = hdl_end && sel_valid && (sel_lvl > top_lvl);
   assign preempt     = !hdl_end && sel_valid && (sel_lvl > cur_lvl);
   assign dispatch    = take_on_end || preempt;
   assign pop         = hdl_end && !take_on_end;
   assign trap_arm    = dispatch && (sel_vec >= VEC_W'(NUM_SRC));

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_pend
      always_ff @(posedge clk) begin
         if (!rst_n) pend_q[i] <= 1'b0;
         else pend_q[i] <= (pend_q[i] && !(dispatch && sel_vec == VEC_W'(i))) || irq_req[i];
      end
   end

   for (genvar t = 0; t < TRAP_N; t++) begin : g_trap
      always_ff @(posedge clk) begin
         if (!rst_n) trap_pend_q[t] <= 1'b0;
         else trap_pend_q[t] <= (trap_pend_q[t] && !(dispatch && sel_vec == VEC_W'(NUM_SRC + t)))
                                || trap_req[t];
      end
   end

   irq_lvl_stack #(.DEPTH(NUM_LVL), .LVL_W(LVL_W)) u_stk (
      .clk(clk), .rst_n(rst_n), .push(preempt), .pop(pop),
      .push_lvl(cur_lvl), .top_lvl(top_lvl), .ovf(stk_ovf)
   );

   irq_trap_watch #(.TRAP_WAIT(TRAP_WAIT)) u_wd (
      .clk(clk), .rst_n(rst_n), .arm(trap_arm), .ack(trap_ack), .rst_req(reset_req)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_lvl   <= '0;
         grant     <= 1'b0;
         grant_vec <= '0;
      end else begin
         grant <= dispatch;
         if (dispatch) begin
            cur_lvl   <= sel_lvl;
            grant_vec <= sel_vec;
         end else if (pop) begin
            cur_lvl <= top_lvl;
         end
      end
   end

   // R3
   grant_up_chk : assert property (@(posedge clk) disable iff (!rst_n)
      (grant && !$past(hdl_done)) |-> cur_lvl > $past(cur_lvl));

   // R4
   lvl_rise_chk : assert property (@(posedge clk) disable iff (!rst_n)
      (cur_lvl > $past(cur_lvl)) |-> grant);

   // R8
   user_below_top_chk : assert property (@(posedge clk) disable iff (!rst_n)
      (grant && grant_vec < VEC_W'(NUM_SRC)) |-> cur_lvl != TOP);

   // R8
   trap_at_top_chk : assert property (@(posedge clk) disable iff (!rst_n)
      (grant && grant_vec >= VEC_W'(NUM_SRC)) |-> cur_lvl == TOP);

   // R10
   idle_done_chk : assert property (@(posedge clk) disable iff (!rst_n)
      (hdl_done && cur_lvl == '0 && !preempt) |=> cur_lvl == '0);
endmodule

// File: tb/sim_nest_irq_arbiter.sv
`timescale 1ns/1ps
module sim_nest_irq_arbiter;
   import irq_arb_pkg::*;

   localparam int NUM_SRC   = 16;
   localparam int NUM_LVL   = 8;
   localparam int TRAP_WAIT = 16;
   localparam int LVL_W     = $clog2(NUM_LVL);
   localparam int SRC_W     = $clog2(NUM_SRC);
   localparam int VEC_W     = $clog2(NUM_SRC + TRAP_N);

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic [NUM_SRC-1:0] irq_req = '0;
   logic               prio_we = 1'b0;
   logic [SRC_W-1:0]   prio_sel = '0;
   logic [LVL_W-1:0]   prio_val = '0;
   logic [TRAP_N-1:0]  trap_req = '0;
   logic               trap_ack = 1'b0;
   logic               hdl_done = 1'b0;
   logic               grant;
   logic [VEC_W-1:0]   grant_vec;
   logic [LVL_W-1:0]   cur_lvl;
   logic               reset_req;
   logic               stk_ovf;

   int n_chk = 0;
   int n_fail = 0;
   int exp_q[$];
   string exp_tag[$];

   always #2.5 clk = ~clk;

   nest_irq_arbiter #(.NUM_SRC(NUM_SRC), .NUM_LVL(NUM_LVL), .TRAP_WAIT(TRAP_WAIT)) u0 (
      .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .prio_we(prio_we),
      .prio_sel(prio_sel), .prio_val(prio_val), .trap_req(trap_req),
      .trap_ack(trap_ack), .hdl_done(hdl_done), .grant(grant),
      .grant_vec(grant_vec), .cur_lvl(cur_lvl), .reset_req(reset_req),
      .stk_ovf(stk_ovf)
   );

   task automatic chk(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic expect_grant(string tag, int vec, int lvl);
      exp_q.push_back(vec * 64 + lvl);
      exp_tag.push_back(tag);
   endtask

   task automatic wr_prio(int idx, int val);
      prio_we = 1'b1; prio_sel = SRC_W'(idx); prio_val = LVL_W'(val);
      tick(1);
      prio_we = 1'b0;
   endtask

   task automatic pulse_req(logic [NUM_SRC-1:0] m);
      irq_req = m; tick(1); irq_req = '0;
   endtask

   task automatic pulse_trap(logic [TRAP_N-1:0] m);
      trap_req = m; tick(1); trap_req = '0;
   endtask

   task automatic finish_hdl();
      hdl_done = 1'b1; tick(1); hdl_done = 1'b0;
   endtask

   task automatic ack_trap();
      trap_ack = 1'b1; tick(1); trap_ack = 1'b0;
   endtask

   // monitor: every grant must match the next expected item
   always @(negedge clk) begin
      if (rst_n && grant) begin
         if (exp_q.size() == 0) begin
            n_chk++; n_fail++;
            $display("FAIL R11: unexpected grant actual vec %0d lvl %0d expected none",
                     grant_vec, cur_lvl);
         end else begin
            automatic int e = exp_q.pop_front();
            automatic string tg = exp_tag.pop_front();
            chk({tg, " vec"}, int'(grant_vec), e / 64);
            chk({tg, " lvl"}, int'(cur_lvl), e % 64);
         end
      end
   end

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(1);
      // R1 reset state
      chk("R1 cur_lvl", int'(cur_lvl), 0);
      chk("R1 grant", int'(grant), 0);
      chk("R1 reset_req", int'(reset_req), 0);
      chk("R1 stk_ovf", int'(stk_ovf), 0);
      // R1 unprogrammed source stays masked
      pulse_req(16'h0040);
      tick(3);
      chk("R1 masked src", int'(cur_lvl), 0);

      wr_prio(0, 2); wr_prio(1, 5); wr_prio(2, 5);
      wr_prio(3, 3); wr_prio(4, 7); wr_prio(5, 1);
      tick(2);
      chk("R1 no grant after writes", int'(cur_lvl), 0);

      // R3 preemption from background
      expect_grant("R3 src0", 0, 2);
      pulse_req(16'h0001); tick(1);
      chk("R3 cur", int'(cur_lvl), 2);

      // R4 lower level waits
      pulse_req(16'h0020); tick(2);
      chk("R4 lower pending", int'(cur_lvl), 2);

      // R3 nested preemption
      expect_grant("R3 src3", 3, 3);
      pulse_req(16'h0008); tick(1);
      chk("R3 nested cur", int'(cur_lvl), 3);

      // R4 equal level waits
      pulse_req(16'h0008); tick(2);
      chk("R4 equal pending", int'(cur_lvl), 3);

      // R6 completion dispatches waiting equal request above stack top
      expect_grant("R6 src3 again", 3, 3);
      finish_hdl();
      chk("R6 cur", int'(cur_lvl), 3);

      // R7 resume suspended level 2
      finish_hdl();
      chk("R7 resume", int'(cur_lvl), 2);
      tick(1);
      chk("R7 stays", int'(cur_lvl), 2);

      // R6 src5 (level 1) outranks background on completion
      expect_grant("R6 src5", 5, 1);
      finish_hdl();
      chk("R6 cur lvl1", int'(cur_lvl), 1);

      finish_hdl();
      chk("R7 back to 0", int'(cur_lvl), 0);

      // R10 completion at background ignored
      finish_hdl(); tick(1);
      chk("R10 idle done", int'(cur_lvl), 0);

      // R5 tie-break
      expect_grant("R5 src1", 1, 5);
      pulse_req(16'h0006); tick(1);
      chk("R5 cur", int'(cur_lvl), 5);
      expect_grant("R5 src2", 2, 5);
      finish_hdl();
      finish_hdl();
      chk("R5 unwound", int'(cur_lvl), 0);

      // R2 clamp of level 7 to 6
      expect_grant("R2 src4", 4, 6);
      pulse_req(16'h0010); tick(1);
      chk("R2 clamped", int'(cur_lvl), 6);

      // R8 two traps, lowest cause first, then the next on completion
      expect_grant("R8 addr trap", NUM_SRC + int'(TRAP_ADDR), 7);
      pulse_trap(4'b1010); tick(1);
      chk("R8 trap lvl", int'(cur_lvl), 7);
      ack_trap();
      expect_grant("R8 osc trap", NUM_SRC + int'(TRAP_OSC), 7);
      finish_hdl();
      ack_trap();
      finish_hdl();
      chk("R8 user resumed", int'(cur_lvl), 6);
      finish_hdl();
      chk("R8 unwound", int'(cur_lvl), 0);
      tick(TRAP_WAIT + 4);
      chk("R9 acked no reset", int'(reset_req), 0);

      // R9 unacknowledged trap
      expect_grant("R9 divz trap", NUM_SRC + int'(TRAP_DIVZ), 7);
      pulse_trap(4'b0001); tick(1);
      chk("R9 before timeout", int'(reset_req), 0);
      tick(TRAP_WAIT + 3);
      chk("R9 reset_req", int'(reset_req), 1);
      tick(4);
      chk("R9 sticky", int'(reset_req), 1);

      // R11 every strobe granted exactly once
      tick(4);
      chk("R11 leftover expected grants", exp_q.size(), 0);
      // R12 no overflow
      chk("R12 stk_ovf", int'(stk_ovf), 0);

      summary();
      $finish;
   end
endmodule